// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block chooses one interrupt among five request lines for a small 8-bit processor core. One line cannot be masked and always wins. Three level lines come next, ranked 7.5, 6.5 and then 5.5, and each carries its own vector. A general request comes last and has no internal vector, so the core must obtain that address from outside. The core tells the controller where its machine cycles and its instructions end. Requests are captured at each machine-cycle boundary, which can fall in the middle of an instruction. The captured set is then arbitrated when the instruction completes.

Software-visible control is limited to two things: a three-bit mask for the level lines and a global enable. The non-maskable line ignores both. Accepting any maskable request clears the global enable. The 7.5 line is edge-triggered and stays pending until it is serviced. All other lines follow their level.

A separate bus-hold path grants an external bus request only when an instruction completes. While the core is halted, or while a grant is active, the block shows that the buses are released.

Top module: `prio_intc`

## Requirements
- R1: After a synchronous active-low reset, `irq_take`, `bus_grant`, `bus_released` and `ien` are 0 and all mask bits are set (all level lines masked).
- R2: Priority, highest first, is the non-maskable line, then level 7.5, level 6.5, level 5.5, and last the general request. `irq_src` encodes them as 1, 2, 3, 4, 5.
- R3: Each accepted source drives a vector on `irq_vec`: 0024h for the non-maskable line, 003Ch for level 7.5, 0034h for level 6.5 and 002Ch for level 5.5. For the general request `irq_vec` is 0000h and `irq_ext` is 1. `irq_ext` is 0 for every other source.
- R4: A level line takes part only when its mask bit is 0 and `ien` is 1. Mask bit 2 controls 7.5, bit 1 controls 6.5 and bit 0 controls 5.5. The general request takes part only when `ien` is 1. The non-maskable line ignores both the mask and `ien`.
- R5: When a maskable source is accepted, `ien` is cleared. When the non-maskable line is accepted, `ien` keeps its value.
- R6: Requests are captured only on cycles where `mcycle_end` is high. A captured request stays eligible until the next capture, even if its line drops. A line that rises after the last capture is not seen.
- R7: An accept happens only on a cycle with `instr_end` high and at least one eligible request. `irq_take` is then high for exactly the next cycle.
- R8: A rising edge on level 7.5 is held pending after the line falls again, and the pending state is cleared when 7.5 is accepted.
- R9: Levels 6.5 and 5.5 are not held: a pulse that ends before a capture has no effect.
- R10: `bus_grant` rises only in the cycle after an `instr_end` cycle that sees `bus_req` high. It falls in the cycle after `bus_req` is seen low.
- R11: `bus_released` is high whenever `halted` or `bus_grant` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_req | input | 1 | Non-maskable request |
| lvl_req | input | 3 | Level requests: bit 2 = 7.5, bit 1 = 6.5, bit 0 = 5.5 |
| gen_req | input | 1 | General non-vectored request |
| mcycle_end | input | 1 | Machine-cycle boundary strobe (capture point) |
| instr_end | input | 1 | Instruction completion strobe (accept point) |
| mask_wr | input | 1 | Load `mask_val` into the mask register |
| mask_val | input | 3 | New mask value; a 1 masks the level line |
| ien_wr | input | 1 | Load `ien_val` into the global enable |
| ien_val | input | 1 | New global enable value |
| halted | input | 1 | Core is in halt state |
| bus_req | input | 1 | External bus request |
| irq_take | output | 1 | One-cycle accept pulse |
| irq_src | output | 3 | Accepted source code |
| irq_vec | output | 16 | Vector address of the accepted source |
| irq_ext | output | 1 | Vector must be supplied externally |
| ien | output | 1 | Global enable state |
| bus_grant | output | 1 | Bus request granted |
| bus_released | output | 1 | Buses are released |

## Verification
The hardest case to reach is a request that is eligible at the accept point even though its line is no longer high. There are two forms of it. One is a level line that was captured mid-instruction and then dropped. The other is a 7.5 edge that arrived while interrupts were disabled. The bench brings these about by separating the `mcycle_end` and `instr_end` strobes by several cycles and toggling the lines in between. It also sweeps every combination of request pattern, mask and enable, and compares each accept against an arithmetic priority computation.

// File: rtl/prio_intc_pkg.sv
// Shared source codes and vector map for the interrupt controller.
package prio_intc_pkg;
    localparam int NSRC  = 5;   // sources, index 0 = highest priority
    localparam int NLVL  = 3;   // vectored maskable level lines
    localparam int IDXW  = $clog2(NSRC);
    localparam int VECW  = 16;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_NMI  = 3'd1,
        SRC_L75  = 3'd2,
        SRC_L65  = 3'd3,
        SRC_L55  = 3'd4,
        SRC_GEN  = 3'd5
    } src_e;

    // Vector address for a priority index; the general request has none.
    function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
        case (idx)
            3'd0:    vec_of = 16'h0024;
            3'd1:    vec_of = 16'h003C;
            3'd2:    vec_of = 16'h0034;
            3'd3:    vec_of = 16'h002C;
            default: vec_of = 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/edge_hold.sv
// Rising-edge pending latch. Assumes raw is synchronous to clk.
// The set from a new edge wins over a clear in the same cycle.
module edge_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic rise;

    assign rise = raw & ~prev_q;

    // Track the previous line value and the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= raw;
            if (rise)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end

    // R8
    edge_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pend);
endmodule

// File: rtl/irq_pick.sv
// Fixed-priority picker: the lowest set index wins. Purely combinational.
module irq_pick #(
    parameter int N  = 5,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the lowest priority upward so the highest priority remains.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/bus_hold.sv
// Bus request handling: grants only at instruction completion and drops as
// soon as the request is withdrawn. Shows release during halt as well.
module bus_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req,
    input  logic instr_end,
    input  logic halted,
    output logic grant,
    output logic released
);
    // Grant register: set at an instruction boundary, cleared on withdrawal.
    always_ff @(posedge clk) begin
        if (!rst_n)
            grant <= 1'b0;
        else if (!bus_req)
            grant <= 1'b0;
        else if (instr_end)
            grant <= 1'b1;
    end

    assign released = grant | halted;

    // R10
    grant_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant) |-> $past(instr_end) && $past(bus_req));
    // R10
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !bus_req) |=> !grant);
endmodule

// File: rtl/prio_intc.sv
// Five-source fixed-priority interrupt controller with a bus-hold path.
// It captures requests at machine-cycle ends and accepts at instruction ends.
// It assumes both strobes are synchronous, single-cycle pulses from the core.
module prio_intc
    import prio_intc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nmi_req,
    input  logic [2:0]  lvl_req,
    input  logic        gen_req,
    input  logic        mcycle_end,
    input  logic        instr_end,
    input  logic        mask_wr,
    input  logic [2:0]  mask_val,
    input  logic        ien_wr,
    input  logic        ien_val,
    input  logic        halted,
    input  logic        bus_req,
    output logic        irq_take,
    output logic [2:0]  irq_src,
    output logic [15:0] irq_vec,
    output logic        irq_ext,
    output logic        ien,
    output logic        bus_grant,
    output logic        bus_released
);
    logic [NSRC-1:0] samp_q;
    logic [NSRC-1:0] fresh;
    logic [NSRC-1:0] elig;
    logic [NLVL-1:0] mask_q;
    logic            pend75;
    logic            found;
    logic [IDXW-1:0] win;
    logic            take_now;
    logic            win_maskable;

    edge_hold u_edge75 (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (lvl_req[2]),
        .clr   (take_now && win == IDXW'(1)),
        .pend  (pend75)
    );

    // Priority-ordered view of the current request lines.
    assign fresh = {gen_req, lvl_req[0], lvl_req[1], pend75, nmi_req};

    // Eligibility per source: the non-maskable line is always eligible,
    // the level lines use the mask and enable, the general line the enable.
    always_comb begin
        elig[0] = samp_q[0];
        for (int k = 1; k <= NLVL; k++)
            elig[k] = samp_q[k] & ien & ~mask_q[NLVL-k];
        elig[NSRC-1] = samp_q[NSRC-1] & ien;
    end

    irq_pick #(.N(NSRC), .IW(IDXW)) u_pick (
        .elig  (elig),
        .found (found),
        .idx   (win)
    );

    assign take_now     = instr_end & found;
    assign win_maskable = (win != '0);

    // Capture register: reload at machine-cycle ends, drop the serviced bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else begin
            logic [NSRC-1:0] nxt;
            nxt = mcycle_end ? fresh : samp_q;
            if (take_now)
                nxt[win] = 1'b0;
            samp_q <= nxt;
        end
    end

    // Mask and global enable; an accepted maskable source clears the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            ien    <= 1'b0;
        end else begin
            if (mask_wr)
                mask_q <= mask_val;
            if (take_now && win_maskable)
                ien <= 1'b0;
            else if (ien_wr)
                ien <= ien_val;
        end
    end

    // Accept outputs, registered for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_take <= 1'b0;
            irq_src  <= SRC_NONE;
            irq_vec  <= '0;
            irq_ext  <= 1'b0;
        end else begin
            irq_take <= take_now;
            if (take_now) begin
                irq_src <= 3'(win) + 3'd1;
                irq_vec <= vec_of(win);
                irq_ext <= (win == IDXW'(NSRC-1));
            end
        end
    end

    bus_hold u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .instr_end (instr_end),
        .halted    (halted),
        .grant     (bus_grant),
        .released  (bus_released)
    );

    // R7
    take_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> $past(instr_end));
    // R5
    ien_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_src != SRC_NMI) |-> !ien);
    // R3
    ext_only_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && irq_ext) |-> irq_src == SRC_GEN);
    // R2
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_now |-> $onehot(elig & (NSRC'(1) << win)));
endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 0, gen_req = 0, mcycle_end = 0, instr_end = 0;
    logic [2:0]  lvl_req = 0, mask_val = 0;
    logic        mask_wr = 0, ien_wr = 0, ien_val = 0, halted = 0, bus_req = 0;
    logic        irq_take, irq_ext, ien, bus_grant, bus_released;
    logic [2:0]  irq_src;
    logic [15:0] irq_vec;
    int          n_run = 0, n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    prio_intc dut_i (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        {nmi_req, gen_req, lvl_req, mcycle_end, instr_end} = '0;
        {mask_wr, ien_wr, halted, bus_req} = '0;
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
    endtask

    task automatic set_cfg(input logic [2:0] m, input logic e);
        mask_val = m; mask_wr = 1; ien_val = e; ien_wr = 1; cyc(1);
        mask_wr = 0; ien_wr = 0;
    endtask

    task automatic pulse_mc; mcycle_end = 1; cyc(1); mcycle_end = 0; endtask
    task automatic pulse_ie; instr_end = 1; cyc(1); instr_end = 0; endtask

    initial begin
        // watchdog
        #4000000;
        n_run++; n_fail++;
        $display("FAIL watchdog act=0 exp=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk(!irq_take && !ien && !bus_grant && !bus_released, "R1 reset outputs",
            {irq_take, ien, bus_grant, bus_released}, 0);
        set_cfg(3'b000, 1'b1); cyc(1);
        lvl_req = 3'b011; pulse_mc(); pulse_ie();
        chk(irq_take && irq_src == 3, "R1 mask set after reset then cleared", irq_src, 3);
        do_reset();
        ien_val = 1; ien_wr = 1; cyc(1); ien_wr = 0;
        lvl_req = 3'b011; pulse_mc(); pulse_ie();
        chk(!irq_take, "R1 reset mask blocks levels", irq_take, 0);

        // R2 R3 R4 R5 exhaustive sweep over requests, mask and enable
        for (int p = 0; p < 32; p++) begin
            for (int m = 0; m < 8; m++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [4:0] el;
                    int w;
                    int xv;
                    do_reset();
                    set_cfg(m[2:0], e[0]);
                    nmi_req = p[0]; lvl_req = {p[1], p[2], p[3]}; gen_req = p[4];
                    cyc(2);
                    pulse_mc(); cyc(1); pulse_ie();
                    el[0] = p[0];
                    el[1] = p[1] & e[0] & ~m[2];
                    el[2] = p[2] & e[0] & ~m[1];
                    el[3] = p[3] & e[0] & ~m[0];
                    el[4] = p[4] & e[0];
                    w = -1;
                    for (int k = 4; k >= 0; k--) if (el[k]) w = k;
                    if (w < 0) begin
                        chk(!irq_take, "R4 no eligible source", irq_take, 0);
                    end else begin
                        xv = (w == 0) ? 'h24 : (w == 1) ? 'h3C : (w == 2) ? 'h34 :
                             (w == 3) ? 'h2C : 0;
                        chk(irq_take && irq_src == w + 1, "R2 winner", irq_src, w + 1);
                        chk(irq_vec == xv && irq_ext == (w == 4), "R3 vector",
                            irq_vec, xv);
                        chk(ien == ((w == 0) ? e[0] : 1'b0), "R5 enable after accept",
                            ien, (w == 0) ? e : 0);
                    end
                end
            end
        end

        // R6 capture only at machine-cycle ends
        do_reset(); set_cfg(3'b000, 1'b1);
        pulse_mc(); lvl_req[1] = 1; cyc(2); pulse_ie();
        chk(!irq_take, "R6 late request unseen", irq_take, 0);
        pulse_mc(); lvl_req[1] = 0; cyc(3); pulse_ie();
        chk(irq_take && irq_src == 3, "R6 captured request held", irq_src, 3);

        // R7 one-cycle pulse
        cyc(1);
        chk(!irq_take, "R7 take lasts one cycle", irq_take, 0);
        do_reset(); set_cfg(3'b000, 1'b1);
        nmi_req = 1; pulse_mc(); cyc(3);
        chk(!irq_take, "R7 no accept without instr_end", irq_take, 0);
        nmi_req = 0;

        // R8 edge latch on 7.5
        do_reset();
        lvl_req[2] = 1; cyc(1); lvl_req[2] = 0; cyc(3);
        set_cfg(3'b000, 1'b1);
        pulse_mc(); pulse_ie();
        chk(irq_take && irq_src == 2 && irq_vec == 16'h003C, "R8 held edge accepted",
            irq_src, 2);
        set_cfg(3'b000, 1'b1);
        pulse_mc(); pulse_ie();
        chk(!irq_take, "R8 cleared after service", irq_take, 0);

        // R9 level lines not held
        do_reset(); set_cfg(3'b000, 1'b1);
        lvl_req[0] = 1; cyc(1); lvl_req[0] = 0; lvl_req[1] = 1; cyc(1); lvl_req[1] = 0;
        cyc(1); pulse_mc(); pulse_ie();
        chk(!irq_take, "R9 short level pulse ignored", irq_take, 0);

        // R10 bus grant at instruction boundary
        do_reset();
        bus_req = 1; cyc(3);
        chk(!bus_grant, "R10 no grant mid-instruction", bus_grant, 0);
        pulse_mc();
        chk(!bus_grant, "R10 machine cycle end no grant", bus_grant, 0);
        pulse_ie();
        chk(bus_grant && bus_released, "R10 grant at boundary", bus_grant, 1);
        bus_req = 0; cyc(1);
        chk(!bus_grant && !bus_released, "R10 grant drops", bus_grant, 0);

        // R11 release during halt
        halted = 1; #1;
        chk(bus_released && !bus_grant, "R11 halted releases", bus_released, 1);
        halted = 0; #1;
        chk(!bus_released, "R11 release ends", bus_released, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule